// File: doc/BRIEF.md
# SPI chip-select timing controller

This block owns the chip-select lines of a serial flash or peripheral controller. It asserts one of several active-low chip selects when the transfer sequencer asks to start. It holds the serial clock gated off for a programmable lead delay and then opens the clock. When a transfer ends it closes the clock, waits a programmable trail delay and a data-hold delay, and releases chip select. After release it keeps chip select high for a programmable minimum gap. Every delay is a 4-bit count of controller clock cycles, and the value 0 adds no delay.

A transfer that ends without its close flag parks the block with chip select still low, so the next start continues on the same device without a new lead delay. A stop request does not cut a unit short. It is remembered and acts at the next unit-boundary strobe, or at once if the block is parked. A start that arrives while the block is winding down is held and served as soon as the gap allows.

Top module: `spi_cs_timer`

## Requirements
- R1: After a synchronous active-low reset all chip selects are high and `sclk_en`, `data_oe` and `busy` are 0.
- R2: A start in idle drives low, from the next cycle, only the line chosen by `cs_sel` (value 0 selects `cs_n[0]`, value 1 selects `cs_n[1]`), and `busy` goes high. The choice is captured at that start, so a later change of `cs_sel` has no effect while chip select is low.
- R3: `sclk_en` rises L cycles after chip select goes low, where L is `cs_timing[3:0]`, or in the same cycle when L is 0. It is high only while a chip select is low.
- R4: A transfer-done with `xfer_close` set drops `sclk_en` in the next cycle, and chip select goes high T+H cycles after that, with T = `cs_timing[7:4]` and H = `cs_timing[11:8]`.
- R5: `data_oe` is high while the clock runs and through the trail and hold delays, and is low from the cycle chip select goes high.
- R6: A transfer-done without `xfer_close` stops the clock but keeps chip select low and `busy` high. The next start reopens the clock in the following cycle with no lead delay.
- R7: A stop request during a running transfer keeps the clock running until a `unit_edge` strobe, which may come in the same cycle. The end sequence of R4 then starts from that strobe. A stop request while parked starts the end sequence at once.
- R8: Once released, chip select stays high for at least max(G,1) cycles, with G = `cs_timing[15:12]`. `busy` stays high for exactly G cycles after release.
- R9: A start made during the trail, hold or gap delay is held. Chip select goes low again exactly when the gap expires, or one cycle after release when G is 0.
- R10: A stop request while idle is ignored and is not remembered. A start request during the lead delay or a running transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_timing | input | 16 | Delays: lead [3:0], trail [7:4], hold [11:8], gap [15:12] |
| cs_sel | input | 1 | Chip select to drive, captured at start |
| start_req | input | 1 | Start or continue a transfer (one-cycle pulse) |
| xfer_done | input | 1 | The sequencer finished its current transfer |
| xfer_close | input | 1 | Qualifies `xfer_done`: release chip select afterwards |
| stop_req | input | 1 | Request to end at the next unit boundary |
| unit_edge | input | 1 | Strobe marking a unit boundary of the running transfer |
| cs_n | output | 2 | Active-low chip selects |
| sclk_en | output | 1 | Gate for the serial clock generator |
| data_oe | output | 1 | Data output lines are driven or held |
| busy | output | 1 | High from the start until the gap delay has run out |

## Verification
All outputs come straight from registered state, so each result is due a fixed number of edges after the stimulus edge. Chip select is due one edge after start. The clock gate is due L edges after that. Release is due T+H edges after the done or boundary edge, and `busy` falls G edges after release. The bench drives and samples on the falling edge. It counts falling edges from the stimulus edge until each output changes and compares that count with the delay taken from the fields it programmed. Single-cycle checks are made exactly on the edge where the output is due.

// File: rtl/cst_pkg.sv
// Shared types for the chip-select timing controller.
// Assumes: four delay fields in the fixed order lead, trail, hold, gap.
package cst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_PARK,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP
    } cst_state_e;

    localparam int unsigned N_DLY     = 4;
    localparam int unsigned DLY_LEAD  = 0;
    localparam int unsigned DLY_TRAIL = 1;
    localparam int unsigned DLY_HOLD  = 2;
    localparam int unsigned DLY_GAP   = 3;

endpackage

// File: rtl/cst_delay_cnt.sv
// Down-counter shared by all timed states.
// It loads a nonzero delay and flags the last cycle of that delay.
// Assumes: the sequencer never loads zero and skips zero-length states itself.
module cst_delay_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    // Load a new delay or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == W'(1));

    // R3
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/cst_sticky.sv
// Pending-request flag: set by a pulse, held until consumed.
// Assumes: clear wins over set in the same cycle.
module cst_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold a request until the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end

endmodule

// File: rtl/cst_cs_drive.sv
// Decodes the captured select into active-low chip-select lines.
// Assumes: sel is stable while active is high.
module cst_cs_drive #(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned SEL_W  = 1
) (
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_line
        assign cs_n[gi] = !(active && (sel == SEL_W'(gi)));
    end

endmodule

// File: rtl/spi_cs_timer.sv
// Chip-select timing controller.
// It sequences lead, run, trail, hold and gap around each serial transfer,
// parks with chip select held between transfers that are not closed, and
// defers a stop to the next unit boundary.
// Assumes: cs_timing is static while busy; request inputs are single-cycle
// pulses synchronous to clk.
module spi_cs_timer
    import cst_pkg::*;
#(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned DLY_W  = 4,
    localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int unsigned TIM_W = N_DLY * DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  cs_timing,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic              start_req,
    input  logic              xfer_done,
    input  logic              xfer_close,
    input  logic              stop_req,
    input  logic              unit_edge,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sclk_en,
    output logic              data_oe,
    output logic              busy
);

    localparam int unsigned OFF_W = DLY_W + 1;
    localparam logic [OFF_W-1:0] OFF_MAX = '1;

    cst_state_e       st_q, st_d;
    logic [DLY_W-1:0] dly [N_DLY];
    logic [DLY_W-1:0] dly_lead, dly_trail, dly_hold, dly_gap;
    logic             cnt_ld, cnt_exp;
    logic [DLY_W-1:0] cnt_val;
    logic             take_sel;
    logic [SEL_W-1:0] sel_q;
    logic             start_pend, stop_pend;
    logic             go_start, stop_now, end_seq, cs_on;

    cst_state_e       lead_st, rel_st, hold_st, trl_st;
    logic             lead_ld, rel_ld, hold_ld, trl_ld;
    logic [DLY_W-1:0] rel_val, hold_val, trl_val;

    for (genvar gi = 0; gi < N_DLY; gi++) begin : g_field
        assign dly[gi] = cs_timing[gi*DLY_W +: DLY_W];
    end

    assign dly_lead  = dly[DLY_LEAD];
    assign dly_trail = dly[DLY_TRAIL];
    assign dly_hold  = dly[DLY_HOLD];
    assign dly_gap   = dly[DLY_GAP];

    assign go_start = start_req | start_pend;
    assign stop_now = stop_req | stop_pend;
    assign end_seq  = ((st_q == ST_RUN) &&
                       ((xfer_done && xfer_close) || (unit_edge && stop_now))) ||
                      ((st_q == ST_PARK) && stop_now);

    // Entry into the lead phase, skipped when the lead delay is zero.
    always_comb begin
        lead_ld = (dly_lead != '0);
        lead_st = lead_ld ? ST_LEAD : ST_RUN;
    end

    // Release step: enter the gap, or go idle when the gap is zero.
    always_comb begin
        rel_ld  = (dly_gap != '0);
        rel_st  = rel_ld ? ST_GAP : ST_IDLE;
        rel_val = dly_gap;
    end

    // Hold step: enter hold, or fall through to release.
    always_comb begin
        if (dly_hold != '0) begin
            hold_st = ST_HOLD; hold_ld = 1'b1; hold_val = dly_hold;
        end else begin
            hold_st = rel_st;  hold_ld = rel_ld; hold_val = rel_val;
        end
    end

    // Trail step: enter trail, or fall through to hold.
    always_comb begin
        if (dly_trail != '0) begin
            trl_st = ST_TRAIL; trl_ld = 1'b1; trl_val = dly_trail;
        end else begin
            trl_st = hold_st;  trl_ld = hold_ld; trl_val = hold_val;
        end
    end

    // Next-state and counter-load decision.
    always_comb begin
        st_d     = st_q;
        cnt_ld   = 1'b0;
        cnt_val  = '0;
        take_sel = 1'b0;
        unique case (st_q)
            ST_IDLE: if (go_start) begin
                take_sel = 1'b1;
                st_d     = lead_st;
                cnt_ld   = lead_ld;
                cnt_val  = dly_lead;
            end
            ST_LEAD: if (cnt_exp) st_d = ST_RUN;
            ST_RUN: begin
                if (end_seq) begin
                    st_d = trl_st; cnt_ld = trl_ld; cnt_val = trl_val;
                end else if (xfer_done) begin
                    st_d = ST_PARK;
                end
            end
            ST_PARK: begin
                if (end_seq) begin
                    st_d = trl_st; cnt_ld = trl_ld; cnt_val = trl_val;
                end else if (start_req) begin
                    st_d = ST_RUN;
                end
            end
            ST_TRAIL: if (cnt_exp) begin
                st_d = hold_st; cnt_ld = hold_ld; cnt_val = hold_val;
            end
            ST_HOLD: if (cnt_exp) begin
                st_d = rel_st; cnt_ld = rel_ld; cnt_val = rel_val;
            end
            ST_GAP: if (cnt_exp) begin
                if (go_start) begin
                    take_sel = 1'b1;
                    st_d     = lead_st;
                    cnt_ld   = lead_ld;
                    cnt_val  = dly_lead;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the chip-select choice when a transfer group begins.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= '0;
        else if (take_sel) sel_q <= cs_sel;
    end

    cst_delay_cnt #(.W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_ld),
        .load_val (cnt_val),
        .expire   (cnt_exp)
    );

    cst_sticky u_start_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (start_req && (st_q inside {ST_TRAIL, ST_HOLD, ST_GAP})),
        .clr   (take_sel),
        .q     (start_pend)
    );

    cst_sticky u_stop_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stop_req && (st_q inside {ST_LEAD, ST_RUN})),
        .clr   (end_seq),
        .q     (stop_pend)
    );

    assign cs_on = st_q inside {ST_LEAD, ST_RUN, ST_PARK, ST_TRAIL, ST_HOLD};

    cst_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_drive (
        .active (cs_on),
        .sel    (sel_q),
        .cs_n   (cs_n)
    );

    assign sclk_en = (st_q == ST_RUN);
    assign data_oe = st_q inside {ST_RUN, ST_TRAIL, ST_HOLD};
    assign busy    = (st_q != ST_IDLE);

    // Checker state: cycles chip select has been high since release.
    logic [OFF_W-1:0] off_cnt;
    logic [OFF_W-1:0] gap_min;
    assign gap_min = (dly_gap == '0) ? OFF_W'(1) : OFF_W'(dly_gap);

    // Count released cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              off_cnt <= OFF_MAX;
        else if (cs_n != '1)     off_cnt <= '0;
        else if (off_cnt != OFF_MAX) off_cnt <= off_cnt + 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (cs_n == '1 && !sclk_en && !busy));

    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cs_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && $past(cs_n) != '1) |-> $stable(cs_n));

    // R3
    sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> (cs_n != '1));

    // R4
    close_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && xfer_done && xfer_close) |=> !sclk_en);

    // R6
    park_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && xfer_done && !xfer_close && !unit_edge) |=> (!sclk_en && cs_n != '1));

    // R7
    stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && stop_req && !unit_edge && !xfer_done) |=> (sclk_en && busy));

    // R8
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && $past(cs_n) == '1) |-> (off_cnt >= gap_min));

endmodule

// File: tb/spi_cs_timer_tb.sv
`timescale 1ns/1ps
module spi_cs_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cs_timing = '0;
    logic [0:0]  cs_sel = '0;
    logic        start_req = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_close = 1'b0;
    logic        stop_req = 1'b0;
    logic        unit_edge = 1'b0;
    logic [1:0]  cs_n;
    logic        sclk_en, data_oe, busy;

    int n_cmp = 0;
    int n_mis = 0;
    bit fin = 1'b0;

    always #2 clk = ~clk;

    spi_cs_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cs_timing(cs_timing), .cs_sel(cs_sel),
        .start_req(start_req), .xfer_done(xfer_done), .xfer_close(xfer_close),
        .stop_req(stop_req), .unit_edge(unit_edge), .cs_n(cs_n),
        .sclk_en(sclk_en), .data_oe(data_oe), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    endtask

    function automatic int sel_mask(input int s);
        return (s == 0) ? 2 : 1;
    endfunction

    function automatic int min_gap(input int g);
        return (g == 0) ? 1 : g;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_cfg(input int l, input int t, input int h, input int g);
        cs_timing = {4'(g), 4'(h), 4'(t), 4'(l)};
    endtask

    task automatic go();
        start_req = 1'b1; tick(); start_req = 1'b0;
    endtask

    task automatic close_xfer();
        xfer_done = 1'b1; xfer_close = 1'b1; tick();
        xfer_done = 1'b0; xfer_close = 1'b0;
    endtask

    task automatic wait_clk_on(output int n);
        n = 0;
        while (!sclk_en && n < 64) begin tick(); n++; end
    endtask

    task automatic wait_cs_off(output int n);
        n = 0;
        while (cs_n != 2'b11 && n < 64) begin tick(); n++; end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 64) begin tick(); n++; end
    endtask

    // Checks from the edge that began the end sequence.
    task automatic end_checks(input int t, input int h, input int g);
        int n;
        chk("R4 clock gate off", int'(sclk_en), 0);
        chk("R5 data held in trail/hold", int'(data_oe), int'(t + h > 0));
        wait_cs_off(n);
        chk("R4 release delay", n, t + h);
        chk("R5 data released", int'(data_oe), 0);
        chk("R8 busy at release", int'(busy), int'(g > 0));
        wait_idle(n);
        chk("R8 gap length", n, g);
    endtask

    initial begin
        int n, h;
        void'($urandom(32'd2025));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 cs after reset", int'(cs_n), 3);
        chk("R1 clk gate after reset", int'(sclk_en), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 data after reset", int'(data_oe), 0);

        // R10 and R2: ignored requests and captured select
        set_cfg(2, 1, 1, 1); cs_sel = 1'b0;
        stop_req = 1'b1; tick(); stop_req = 1'b0;
        repeat (3) tick();
        chk("R10 idle stop cs", int'(cs_n), 3);
        chk("R10 idle stop busy", int'(busy), 0);
        go();
        chk("R2 cs select", int'(cs_n), sel_mask(0));
        wait_clk_on(n);
        chk("R3 lead delay", n, 2);
        unit_edge = 1'b1; tick(); unit_edge = 1'b0; tick();
        chk("R10 idle stop not remembered", int'(sclk_en), 1);
        go();
        chk("R10 start while running", int'(sclk_en), 1);
        cs_sel = 1'b1; tick();
        chk("R2 select change ignored", int'(cs_n), sel_mask(0));
        close_xfer();
        end_checks(1, 1, 1);

        // R9: start queued during trail
        set_cfg(1, 3, 2, 5); cs_sel = 1'b1;
        repeat (20) tick();
        go(); wait_clk_on(n);
        close_xfer();
        start_req = 1'b1; tick(); start_req = 1'b0;
        wait_cs_off(n);
        chk("R9 release with queued start", n, 4);
        chk("R9 busy while queued", int'(busy), 1);
        h = 0;
        while (cs_n == 2'b11 && h < 64) begin tick(); h++; end
        chk("R9 queued start at gap end", h, 5);
        chk("R9 queued start cs", int'(cs_n), sel_mask(1));
        wait_clk_on(n);
        chk("R3 lead after queued start", n, 1);
        close_xfer();
        end_checks(3, 2, 5);

        // R8/R9: all delays zero
        set_cfg(0, 0, 0, 0); cs_sel = 1'b0;
        repeat (20) tick();
        go();
        chk("R3 zero lead", int'(sclk_en), 1);
        close_xfer();
        chk("R4 zero trail/hold", int'(cs_n), 3);
        start_req = 1'b1; tick(); start_req = 1'b0;
        chk("R8 one released cycle", int'(cs_n), sel_mask(0));
        close_xfer();
        end_checks(0, 0, 0);

        // R7: stop while parked
        set_cfg(0, 1, 1, 2); cs_sel = 1'b1;
        repeat (20) tick();
        go(); wait_clk_on(n);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R6 parked cs", int'(cs_n), sel_mask(1));
        stop_req = 1'b1; tick(); stop_req = 1'b0;
        end_checks(1, 1, 2);

        // Random transfers
        for (int it = 0; it < 40; it++) begin
            int l, t, hh, g, sel, mode, k;
            l = $urandom % 16; t = $urandom % 16; hh = $urandom % 16; g = $urandom % 16;
            sel = $urandom % 2; mode = $urandom % 3; k = $urandom % 4;
            set_cfg(l, t, hh, g); cs_sel = 1'(sel);
            repeat (20) tick();
            go();
            chk("R2 cs select", int'(cs_n), sel_mask(sel));
            chk("R2 busy at start", int'(busy), 1);
            wait_clk_on(n);
            chk("R3 lead delay", n, l);
            repeat (k) tick();
            if (mode == 1) begin
                xfer_done = 1'b1; tick(); xfer_done = 1'b0;
                chk("R6 clock stopped", int'(sclk_en), 0);
                chk("R6 cs held", int'(cs_n), sel_mask(sel));
                repeat (3) tick();
                chk("R6 still held", int'(cs_n), sel_mask(sel));
                chk("R6 busy parked", int'(busy), 1);
                go();
                chk("R6 resume without lead", int'(sclk_en), 1);
            end
            if (mode == 2) begin
                stop_req = 1'b1;
                if (k == 0) unit_edge = 1'b1;
                tick();
                stop_req = 1'b0; unit_edge = 1'b0;
                if (k != 0) begin
                    repeat (k - 1) tick();
                    chk("R7 clock runs to boundary", int'(sclk_en), 1);
                    chk("R7 busy before boundary", int'(busy), 1);
                    unit_edge = 1'b1; tick(); unit_edge = 1'b0;
                end
            end else begin
                close_xfer();
            end
            end_checks(t, hh, g);
            chk("R8 min gap formula", min_gap(g) >= 1, 1);
        end

        fin = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

endmodule